// File: doc/BRIEF.md
# Descriptor-Driven Interrupt Transfer Engine

This block answers a peripheral's service request by moving one byte between a peripheral I/O location and a memory buffer without involving the CPU. Each channel keeps its transfer state in an eight-byte record in on-chip RAM, not in registers. A request names a channel. The engine reads that channel's record, decrements the item count and runs the transfer as one bus read followed by one bus write. It then writes the changed record bytes back and pulses `done`. When the decremented count reaches zero it also raises `srv_end`, so that a normal interrupt can take over.

The RAM side is a byte-wide port with a one-cycle read latency. The bus side is a single-transfer master. It holds a strobe with address, direction and write data until the slave acknowledges. Neither the RAM nor the bus is arbitrated here.

Top module: `dte_engine`

## Requirements
- R1: While and after a synchronous reset, `done`, `srv_end`, `bus_cyc`, `bus_we` and `ram_we` are low until a request is accepted.
- R2: For an accepted channel c, the record is read from RAM addresses 0x100+8c through 0x100+8c+7. Offsets 0..2 hold the buffer pointer (low, middle, high byte), offset 3 the control byte, offsets 4..5 the I/O address (low, high) and offsets 6..7 the item count (low, high).
- R3: The item count is decremented by one, modulo 2^16, before the transfer. The new value is written back to offsets 6 (low byte) and 7 (high byte).
- R4: Control bit 0 selects the direction. With bit 0 clear, the engine reads the bus at the I/O address zero-extended to 24 bits and writes that byte to the buffer pointer address. With bit 0 set, it reads at the buffer pointer and writes to the I/O address.
- R5: With control bit 1 set, the buffer pointer is incremented by one, modulo 2^24, with carry across its bytes. With bit 1 clear it is unchanged. Either way it is written back to offsets 0..2.
- R6: `srv_end` is high exactly in the cycle of `done` when the decremented count is zero. A stored count of 0 wraps to 0xFFFF and gives no `srv_end`.
- R7: `done` is a one-cycle pulse. With Wr and Ww the wait cycles that the read and write strobes spend before their acknowledges, it appears 17+Wr+Ww clock edges after the edge that accepted the request.
- R8: A bus strobe keeps its address, direction and write data stable until acknowledged. It drops for at least one cycle after every acknowledge, and the read always comes before the write.
- R9: A request seen while idle is accepted at that edge. A request seen while busy is held (one deep) and accepted at the first edge after `done`.
- R10: RAM writes go only to offsets 0, 1, 2, 6 and 7 of the channel being served. The control byte, the I/O address and all other records keep their values.
- R11: A RAM write and a bus strobe are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Service request, one cycle per request |
| req_chan | input | CH_W (4) | Channel index of the request |
| ram_addr | output | RAM_AW (9) | RAM byte address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid one cycle after the address |
| bus_cyc | output | 1 | Bus transfer strobe |
| bus_we | output | 1 | Bus direction, 1 = write |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data, valid with the acknowledge |
| bus_ack | input | 1 | Bus acknowledge, ends the strobe at this edge |
| done | output | 1 | One-cycle service complete pulse |
| srv_end | output | 1 | Count reached zero, high together with done |

## Verification
A service's results come due at fixed offsets from the accepting edge. The two bus transactions complete at edges 10+Wr and 12+Wr+Ww. The five record writes land on the following five edges, and `done` with `srv_end` becomes visible after edge 17+Wr+Ww. The reference model counts edges from each acceptance with the slave's programmed wait. It predicts the value of `done` and `srv_end` for every cycle and compares both at each falling edge. The record bytes and the logged bus transactions are compared in the cycle that `done` is expected, because all of them have landed by then. A request raised during a service enters the model's queue and is counted from the edge after the expected `done`. The same rule governs the design's hold register.

// File: rtl/dte_pkg.sv
package dte_pkg;
  localparam int PTR_W  = 24;
  localparam int IO_W   = 16;
  localparam int CNT_W  = 16;
  localparam int REC_B  = 8;
  localparam int OFS_W  = $clog2(REC_B);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_RDBUS, S_GAP, S_WRBUS, S_WBACK
  } dte_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic [IO_W-1:0]  io;
    logic [7:0]       ctl;
    logic [PTR_W-1:0] ptr;
  } dte_rec_t;
endpackage

// File: rtl/dte_req_hold.sv
module dte_req_hold #(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [CH_W-1:0] req_chan,
  input  logic            busy,
  input  logic            take,
  output logic            go,
  output logic [CH_W-1:0] go_chan
);
  logic            hold_v;
  logic [CH_W-1:0] hold_ch;

  assign go      = hold_v | req_valid;
  assign go_chan = hold_v ? hold_ch : req_chan;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v  <= 1'b0;
      hold_ch <= '0;
    end else if (take) begin
      if (hold_v && req_valid) begin
        hold_ch <= req_chan;
      end else begin
        hold_v <= 1'b0;
      end
    end else if (req_valid && busy) begin
      hold_v  <= 1'b1;
      hold_ch <= req_chan;
    end
  end
endmodule

// File: rtl/dte_rec_regs.sv
module dte_rec_regs
  import dte_pkg::*;
(
  input  logic             clk,
  input  logic             cap_en,
  input  logic [OFS_W-1:0] cap_idx,
  input  logic [7:0]       byte_in,
  output dte_rec_t         rec
);
  logic [REC_B-1:0][7:0] bytes_w;

  for (genvar i = 0; i < REC_B; i++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk) begin
      if (cap_en && (cap_idx == OFS_W'(i))) b_q <= byte_in;
    end
    assign bytes_w[i] = b_q;
  end

  assign rec = dte_rec_t'(bytes_w);
endmodule

// File: rtl/dte_update.sv
module dte_update
  import dte_pkg::*;
#(
  parameter int DIR_BIT = 0,
  parameter int INC_BIT = 1
) (
  input  dte_rec_t          rec,
  output logic [CNT_W-1:0]  new_cnt,
  output logic [PTR_W-1:0]  new_ptr,
  output logic [PTR_W-1:0]  src_addr,
  output logic [PTR_W-1:0]  dst_addr,
  output logic              is_last
);
  logic [PTR_W-1:0] io_ext;

  always_comb begin
    new_cnt  = rec.cnt - CNT_W'(1);
    is_last  = (new_cnt == '0);
    new_ptr  = rec.ctl[INC_BIT] ? rec.ptr + PTR_W'(1) : rec.ptr;
    io_ext   = {{(PTR_W-IO_W){1'b0}}, rec.io};
    src_addr = rec.ctl[DIR_BIT] ? rec.ptr : io_ext;
    dst_addr = rec.ctl[DIR_BIT] ? io_ext  : rec.ptr;
  end
endmodule

// File: rtl/dte_engine.sv
module dte_engine
  import dte_pkg::*;
#(
  parameter int CHANS     = 16,
  parameter int RAM_AW    = 9,
  parameter int DESC_BASE = 256,
  parameter int DIR_BIT   = 0,
  parameter int INC_BIT   = 1,
  localparam int CH_W     = $clog2(CHANS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CH_W-1:0]   req_chan,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic              bus_cyc,
  output logic              bus_we,
  output logic [PTR_W-1:0]  bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  input  logic              bus_ack,
  output logic              done,
  output logic              srv_end
);
  localparam int HI_W = RAM_AW - OFS_W;
  localparam logic [3:0] LAST_RD = 4'(REC_B);
  localparam logic [OFS_W-1:0] OFS_CNT_LO = OFS_W'(6);
  localparam logic [OFS_W-1:0] OFS_CNT_HI = OFS_W'(7);

  dte_state_e       state;
  logic [3:0]       step;
  logic [HI_W-1:0]  base_hi;
  logic [HI_W-1:0]  nxt_hi;
  logic             go, take, busy;
  logic [CH_W-1:0]  go_chan;
  logic             cap_en;
  logic [OFS_W-1:0] cap_idx;
  dte_rec_t         rec;
  logic [CNT_W-1:0] new_cnt;
  logic [PTR_W-1:0] new_ptr, src_addr, dst_addr;
  logic             is_last;

  assign busy    = (state != S_IDLE);
  assign take    = (state == S_IDLE) && go;
  assign nxt_hi  = HI_W'(DESC_BASE >> OFS_W) + HI_W'(go_chan);
  assign cap_en  = (state == S_FETCH) && (step != 4'd0);
  assign cap_idx = OFS_W'(step - 4'd1);

  dte_req_hold #(.CH_W(CH_W)) u_hold (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
    .busy(busy), .take(take), .go(go), .go_chan(go_chan)
  );

  dte_rec_regs u_rec (
    .clk(clk), .cap_en(cap_en), .cap_idx(cap_idx), .byte_in(ram_rdata), .rec(rec)
  );

  dte_update #(.DIR_BIT(DIR_BIT), .INC_BIT(INC_BIT)) u_upd (
    .rec(rec), .new_cnt(new_cnt), .new_ptr(new_ptr),
    .src_addr(src_addr), .dst_addr(dst_addr), .is_last(is_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      step      <= '0;
      base_hi   <= '0;
      ram_addr  <= '0;
      ram_we    <= 1'b0;
      ram_wdata <= '0;
      bus_cyc   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      done      <= 1'b0;
      srv_end   <= 1'b0;
    end else begin
      done    <= 1'b0;
      srv_end <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (go) begin
            base_hi  <= nxt_hi;
            ram_addr <= {nxt_hi, OFS_W'(0)};
            step     <= '0;
            state    <= S_FETCH;
          end
        end
        S_FETCH: begin
          step <= step + 4'd1;
          if (step < LAST_RD - 4'd1) ram_addr <= {base_hi, OFS_W'(step + 4'd1)};
          if (step == LAST_RD) begin
            bus_cyc  <= 1'b1;
            bus_we   <= 1'b0;
            bus_addr <= src_addr;
            state    <= S_RDBUS;
          end
        end
        S_RDBUS: begin
          if (bus_ack) begin
            bus_cyc   <= 1'b0;
            bus_wdata <= bus_rdata;
            state     <= S_GAP;
          end
        end
        S_GAP: begin
          bus_cyc  <= 1'b1;
          bus_we   <= 1'b1;
          bus_addr <= dst_addr;
          state    <= S_WRBUS;
        end
        S_WRBUS: begin
          if (bus_ack) begin
            bus_cyc   <= 1'b0;
            bus_we    <= 1'b0;
            ram_we    <= 1'b1;
            ram_addr  <= {base_hi, OFS_W'(0)};
            ram_wdata <= new_ptr[7:0];
            step      <= '0;
            state     <= S_WBACK;
          end
        end
        S_WBACK: begin
          step <= step + 4'd1;
          case (step)
            4'd0: begin
              ram_addr  <= {base_hi, OFS_W'(1)};
              ram_wdata <= new_ptr[15:8];
            end
            4'd1: begin
              ram_addr  <= {base_hi, OFS_W'(2)};
              ram_wdata <= new_ptr[23:16];
            end
            4'd2: begin
              ram_addr  <= {base_hi, OFS_CNT_LO};
              ram_wdata <= new_cnt[7:0];
            end
            4'd3: begin
              ram_addr  <= {base_hi, OFS_CNT_HI};
              ram_wdata <= new_cnt[15:8];
            end
            default: begin
              ram_we  <= 1'b0;
              done    <= 1'b1;
              srv_end <= is_last;
              state   <= S_IDLE;
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dte_engine_chk.sv
module dte_engine_chk #(
  parameter int CHANS     = 16,
  parameter int RAM_AW    = 9,
  parameter int DESC_BASE = 256,
  parameter int PTR_W     = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              srv_end,
  input logic              bus_cyc,
  input logic              bus_we,
  input logic              bus_ack,
  input logic [PTR_W-1:0]  bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              ram_we,
  input logic [RAM_AW-1:0] ram_addr
);
  localparam logic [RAM_AW-1:0] LO_A = RAM_AW'(DESC_BASE);
  localparam logic [RAM_AW-1:0] HI_A = RAM_AW'(DESC_BASE + CHANS * 8 - 1);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_end_with_done: assert property (@(posedge clk) disable iff (rst)
    srv_end |-> done);

  a_r8_hold_strobe: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !bus_ack) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  a_r8_gap_after_ack: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_ack) |=> !bus_cyc);

  a_r10_wb_offsets: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_addr >= LO_A && ram_addr <= HI_A &&
                ram_addr[2:0] != 3'd3 && ram_addr[2:0] != 3'd4 && ram_addr[2:0] != 3'd5));

  a_r11_no_overlap: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !bus_cyc);

  a_r7_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_cyc && !ram_we));
endmodule

bind dte_engine dte_engine_chk #(
  .CHANS(CHANS), .RAM_AW(RAM_AW), .DESC_BASE(DESC_BASE), .PTR_W(dte_pkg::PTR_W)
) u_chk (
  .clk(clk), .rst(rst), .done(done), .srv_end(srv_end), .bus_cyc(bus_cyc),
  .bus_we(bus_we), .bus_ack(bus_ack), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .ram_we(ram_we), .ram_addr(ram_addr)
);

// File: tb/sim_dte_engine.sv
`timescale 1ns/1ps
module sim_dte_engine;
  localparam int CHANS = 16;
  localparam int RAM_AW = 9;
  localparam int BASE = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              req_valid = 1'b0;
  logic [3:0]        req_chan = '0;
  logic [RAM_AW-1:0] ram_addr;
  logic              ram_we;
  logic [7:0]        ram_wdata;
  logic [7:0]        ram_rdata;
  logic              bus_cyc, bus_we, bus_ack, done, srv_end;
  logic [23:0]       bus_addr;
  logic [7:0]        bus_wdata;
  logic [7:0]        bus_rdata = '0;

  dte_engine u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .done(done), .srv_end(srv_end)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", rq, what, act, exp, $time);
    end
  endtask

  // RAM with a bench-side loading port
  logic [7:0]  ram [0:511];
  logic        tb_we = 1'b0;
  logic [8:0]  tb_a = '0;
  logic [7:0]  tb_d = '0;
  always @(posedge clk) begin
    if (tb_we) ram[tb_a] <= tb_d;
    else if (ram_we) ram[ram_addr] <= ram_wdata;
    ram_rdata <= ram[ram_addr];
  end

  // bus slave with programmable wait
  logic [7:0] bmem [int];
  int wait_w = 0;
  int hcnt = 0;
  bit seen_ack = 0;
  typedef struct packed { logic [23:0] a; logic we; logic [7:0] d; } txn_t;
  txn_t log_q[$];

  function automatic logic [7:0] peek(input logic [23:0] a);
    if (bmem.exists(int'(a))) return bmem[int'(a)];
    return 8'(a * 7 + 3);
  endfunction

  assign bus_ack = bus_cyc && (hcnt == wait_w);
  always @(negedge clk) bus_rdata <= peek(bus_addr);
  always @(posedge clk) begin
    seen_ack <= bus_cyc && bus_ack;
    if (bus_cyc && !bus_ack) hcnt <= hcnt + 1; else hcnt <= 0;
    if (bus_cyc && bus_ack) begin
      log_q.push_back({bus_addr, bus_we, bus_we ? bus_wdata : bus_rdata});
      if (bus_we) bmem[int'(bus_addr)] = bus_wdata;
    end
  end

  // behavioural reference model
  logic [7:0] sh [0:127];
  int q_ch[$];
  bit m_busy = 0, exp_done = 0, exp_end = 0, run_chk = 0;
  int m_cd = 0, m_ch = 0;
  logic [23:0] e_src, e_dst;

  task automatic accept(input int ch);
    int b;
    logic [15:0] c;
    logic [23:0] p;
    logic [7:0] ctl;
    logic [23:0] io;
    b = ch * 8;
    c = {sh[b+7], sh[b+6]} - 16'd1;
    p = {sh[b+2], sh[b+1], sh[b]};
    ctl = sh[b+3];
    io = {8'h00, sh[b+5], sh[b+4]};
    e_src = ctl[0] ? p : io;
    e_dst = ctl[0] ? io : p;
    if (ctl[1]) p = p + 24'd1;
    sh[b] = p[7:0]; sh[b+1] = p[15:8]; sh[b+2] = p[23:16];
    sh[b+6] = c[7:0]; sh[b+7] = c[15:8];
    exp_end = 0;
    m_busy = 1; m_ch = ch; m_cd = 17 + 2 * wait_w;
    e_last = (c == 16'd0);
  endtask
  bit e_last = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; exp_done = 0; exp_end = 0; q_ch.delete();
    end else begin
      exp_done = 0; exp_end = 0;
      if (req_valid) q_ch.push_back(int'(req_chan));
      if (m_busy) begin
        m_cd--;
        if (m_cd == 0) begin
          m_busy = 0; exp_done = 1; exp_end = e_last;
        end
      end else if (q_ch.size() > 0) begin
        accept(q_ch.pop_front());
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst && run_chk) begin
      chk(done == exp_done, "R7", "done", done, exp_done);
      chk(srv_end == exp_end, "R6", "srv_end", srv_end, exp_end);
      if (seen_ack) chk(!bus_cyc, "R8", "strobe gap after ack", bus_cyc, 0);
      if (ram_we) begin
        chk(!bus_cyc, "R11", "ram write during strobe", bus_cyc, 0);
        chk(int'(ram_addr) - BASE - m_ch * 8 inside {0, 1, 2, 6, 7}, "R10", "writeback address",
            ram_addr, BASE + m_ch * 8);
      end
      if (exp_done) begin
        for (int i = 0; i < 128; i++)
          if (ram[BASE + i] !== sh[i])
            chk(0, (i % 8 >= 6) ? "R3" : ((i % 8 <= 2) ? "R5" : "R10"), "record byte", ram[BASE + i], sh[i]);
        chk(1, "R10", "record area", 0, 0);
        chk(log_q.size() == 2, "R8", "transaction count", log_q.size(), 2);
        if (log_q.size() == 2) begin
          txn_t r, w;
          r = log_q.pop_front();
          w = log_q.pop_front();
          chk(r.we == 1'b0 && r.a == e_src, "R2", "read address", r.a, e_src);
          chk(w.we == 1'b1 && w.a == e_dst, "R4", "write address", w.a, e_dst);
          chk(w.d == r.d, "R4", "moved byte", w.d, r.d);
        end else begin
          log_q.delete();
        end
      end
    end
  end

  task automatic put(input int a, input logic [7:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_a = 9'(a); tb_d = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic set_rec(input int ch, input logic [23:0] p, input logic [7:0] ctl,
                         input logic [15:0] io, input logic [15:0] c);
    logic [7:0] v [8];
    v[0] = p[7:0]; v[1] = p[15:8]; v[2] = p[23:16]; v[3] = ctl;
    v[4] = io[7:0]; v[5] = io[15:8]; v[6] = c[7:0]; v[7] = c[15:8];
    for (int k = 0; k < 8; k++) begin
      put(BASE + ch * 8 + k, v[k]);
      sh[ch * 8 + k] = v[k];
    end
  endtask

  task automatic issue(input int ch);
    @(negedge clk);
    req_valid = 1'b1; req_chan = 4'(ch);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    do @(negedge clk); while (m_busy || q_ch.size() > 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < CHANS; c++)
      set_rec(c, 24'(c * 16), 8'h00, 16'(c), 16'h0010);
    set_rec(0, 24'h001000, 8'h02, 16'h0040, 16'd3);
    set_rec(5, 24'h002010, 8'h03, 16'h0051, 16'd1);
    set_rec(15, 24'h003020, 8'h00, 16'h0062, 16'd0);
    set_rec(3, 24'hFFFFFF, 8'h03, 16'h0073, 16'h0100);
    set_rec(2, 24'h00A0FF, 8'h02, 16'h0080, 16'd2);
    set_rec(7, 24'h00B000, 8'h01, 16'h0090, 16'd5);
    @(negedge clk);
    // R1: outputs quiet during reset
    chk(!done && !srv_end && !bus_cyc && !bus_we && !ram_we, "R1", "reset outputs",
        {done, srv_end, bus_cyc, bus_we, ram_we}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !srv_end && !bus_cyc && !bus_we && !ram_we, "R1", "post-reset outputs",
        {done, srv_end, bus_cyc, bus_we, ram_we}, 0);
    run_chk = 1;

    wait_w = 0; issue(0); settle();   // R4 dir 0, R5 increment, R3 3->2
    wait_w = 2; issue(5); settle();   // R4 dir 1, R6 count 1 -> end
    wait_w = 1; issue(15); settle();  // R6 count 0 wraps, R5 no increment
    wait_w = 3; issue(3); settle();   // R5 pointer carry wrap, R3 borrow 0x100 -> 0x0FF
    wait_w = 0; issue(0); settle();
    issue(0); settle();               // R6 third service of channel 0 ends
    wait_w = 1;
    issue(2);                         // R9 second request held while busy
    repeat (3) @(negedge clk);
    issue(7);
    settle();
    chk(ram[BASE + 2 * 8] == 8'h00 && ram[BASE + 2 * 8 + 1] == 8'hA1, "R5", "carry into middle byte",
        {ram[BASE + 17], ram[BASE + 16]}, 16'hA100);
    chk(log_q.size() == 0 && q_ch.size() == 0, "R9", "all requests served", q_ch.size(), 0);
    run_chk = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule